// File: doc/BRIEF.md
# Serial-Bus Byte Memory Controller

This block is the command and control logic of a byte-wide nonvolatile memory that sits on a four-wire serial peripheral bus. The four wires are clock, data in, data out and an active-low select. A plain synthesizable RAM array stands in for the cells. A host selects the block and shifts in an 8-bit opcode, then any address and data, most significant bit first. Data in is sampled on rising clock edges, and read data is driven on falling edges (SPI mode 0). All bus pins are oversampled by the system clock `clk`. The bus clock must therefore run well below `clk`.

Writes are guarded in three ways. A write-enable flag must be set first. A write-protect pin must be high. Finally, a two-bit protection level fences off the top quarter, the top half or all of the array. Accepted data is collected in a page buffer. It is committed by a self-timed busy period that lasts a fixed number of `clk` cycles. Reads continue through the array for as long as the host keeps clocking. An active-low hold input freezes a transfer in mid-byte. Select still ends a transaction while hold is active.

Array size is set by `ADDR_W`. The default is 2048 bytes; set it to 13 for the full 8192-byte array. The page size is set by `PAGE_BYTES` (default 32) and the busy length by `WRITE_CYCLES`.

Top module: `spi_nvm_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 and `miso_oe` is low.
- R2: `miso_oe` is high only while `cs_n` is low and `hold_n` is high. It follows those pins within two `clk` cycles. Output bits change only after falling bus-clock edges.
- R3: Opcode 0x06 sets the write-enable flag and 0x04 clears it. Opcode 0x05 returns the status byte, repeated while clocking continues. Status layout: bit 0 = busy, bit 1 = write enable, bits 3:2 = protection level, bits 7:4 = 0.
- R4: Opcode 0x03 is followed by a 16-bit address; only the low `ADDR_W` bits are used. The block then returns bytes from consecutive addresses, wrapping from the last address to 0.
- R5: Opcode 0x02 while the write-enable flag is clear is ignored, and the array is not changed.
- R6: In a write, data bytes go to consecutive addresses that wrap inside the current `PAGE_BYTES` page. They are committed when `cs_n` rises, if at least one whole byte arrived. Trailing bits of an incomplete byte are dropped.
- R7: A committed write clears the write-enable flag. It holds status bit 0 high for `WRITE_CYCLES` clock cycles. Every opcode except 0x05 is ignored while bit 0 is high.
- R8: Opcode 0x01 loads data bits 3:2 into the protection level when `cs_n` rises, and then clears the write-enable flag. It is ignored while the write-enable flag is clear.
- R9: Protection level 0 protects nothing, 1 protects the top quarter, 2 the top half and 3 the whole array. Bytes aimed at protected addresses are discarded. Unprotected bytes of the same write are still stored.
- R10: While `wp_n` is low, opcodes 0x02 and 0x01 are ignored, and the write-enable flag keeps its value.
- R11: While `hold_n` is low, bus-clock and data-in edges are ignored and `miso_oe` is low. The transfer resumes where it stopped once `hold_n` rises. `cs_n` going high during hold ends the transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Bus clock from the host, idle low |
| cs_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data from the host |
| hold_n | input | 1 | Active-low pause |
| wp_n | input | 1 | Active-low write protect |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for `miso` |

## Verification
The assertions assume that the bus clock is much slower than `clk`, so that every bus edge is seen as a single-cycle pulse. They also assume that `cs_n` only changes while `sck` is low. The bench holds each bus-clock phase for four `clk` cycles. It drives every pin on the falling edge of `clk` and changes select only with the bus clock low, so all stimulus stays inside those assumptions. Hold is asserted only between bus-clock edges, and the bus clock still toggles while hold is low, to show that those edges are frozen out.

// File: rtl/spi_nvm_pkg.sv
package spi_nvm_pkg;

   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_WRDI  = 8'h04;
   localparam logic [7:0] OP_RDSR  = 8'h05;
   localparam logic [7:0] OP_WRSR  = 8'h01;
   localparam logic [7:0] OP_READ  = 8'h03;
   localparam logic [7:0] OP_WRITE = 8'h02;

   typedef enum logic [2:0] {
      ST_CMD, ST_AHI, ST_ALO, ST_RD, ST_WR, ST_RDSR, ST_WRSR, ST_SKIP
   } nvm_st_e;

   // top2 holds the two most significant address bits
   function automatic logic prot_hit(input logic [1:0] lvl, input logic [1:0] top2);
      case (lvl)
         2'd0:    prot_hit = 1'b0;
         2'd1:    prot_hit = &top2;
         2'd2:    prot_hit = top2[1];
         default: prot_hit = 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/spi_nvm_pins.sv
module spi_nvm_pins (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sck,
   input  logic       cs_n,
   input  logic       mosi,
   input  logic       hold_n,
   input  logic       tx_load,
   input  logic [7:0] tx_byte,
   output logic       idle,
   output logic       cs_end,
   output logic       byte_done,
   output logic [7:0] byte_val,
   output logic       miso,
   output logic       miso_oe
);
   logic       sck_r, sck_p, mosi_r, cs_r, cs_p, hold_r;
   logic [2:0] bitcnt;
   logic [6:0] sreg;
   logic [7:0] tx;
   logic       miso_q;
   logic       act, rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_r  <= 1'b0;
         sck_p  <= 1'b0;
         mosi_r <= 1'b0;
         cs_r   <= 1'b1;
         cs_p   <= 1'b1;
         hold_r <= 1'b1;
      end else begin
         sck_r  <= sck;
         sck_p  <= sck_r;
         mosi_r <= mosi;
         cs_r   <= cs_n;
         cs_p   <= cs_r;
         hold_r <= hold_n;
      end
   end

   assign act  = ~cs_r & hold_r;
   assign rise = act & sck_r & ~sck_p;
   assign fall = act & ~sck_r & sck_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bitcnt <= '0;
         sreg   <= '0;
      end else if (cs_r) begin
         bitcnt <= '0;
      end else if (rise) begin
         bitcnt <= bitcnt + 3'd1;
         sreg   <= {sreg[5:0], mosi_r};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx     <= '0;
         miso_q <= 1'b0;
      end else if (cs_r) begin
         miso_q <= 1'b0;
      end else if (tx_load) begin
         tx <= tx_byte;
      end else if (fall) begin
         {miso_q, tx} <= {tx, 1'b0};
      end
   end

   assign idle      = cs_r;
   assign cs_end    = cs_r & ~cs_p;
   assign byte_done = rise & (bitcnt == 3'd7);
   assign byte_val  = {sreg, mosi_r};
   assign miso      = miso_q;
   assign miso_oe   = act;

   a_r11_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_r && !hold_r) |=> $stable(bitcnt));
   a_r2_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(miso_q) |-> $past(fall || cs_r));
endmodule

// File: rtl/spi_nvm_array.sv
module spi_nvm_array #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [7:0]        rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/spi_nvm_store.sv
module spi_nvm_store
   import spi_nvm_pkg::*;
#(
   parameter int ADDR_W       = 11,
   parameter int PAGE_BYTES   = 32,
   parameter int WRITE_CYCLES = 256,
   localparam int PW  = $clog2(PAGE_BYTES),
   localparam int PGW = ADDR_W - PW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bp,
   input  logic              ld_en,
   input  logic [PW-1:0]     ld_idx,
   input  logic [7:0]        ld_byte,
   input  logic              clr_mask,
   input  logic              commit,
   input  logic [PGW-1:0]    pg,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              busy
);
   localparam int CW = $clog2(WRITE_CYCLES + 1);

   initial begin
      a_cfg_page_pow2: assert (PAGE_BYTES == (1 << PW));
      a_cfg_busy_len:  assert (WRITE_CYCLES > PAGE_BYTES);
      a_cfg_addr:      assert (PGW >= 2);
   end

   logic [7:0]        pbuf  [PAGE_BYTES];
   logic              pmask [PAGE_BYTES];
   logic [CW-1:0]     cnt;
   logic [PGW-1:0]    pg_q;
   logic [PW-1:0]     wr_idx;
   logic [ADDR_W-1:0] wr_addr;
   logic              in_win, mem_we;

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_page
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                pmask[g] <= 1'b0;
         else if (clr_mask)                         pmask[g] <= 1'b0;
         else if (ld_en && ld_idx == PW'(g))        pmask[g] <= 1'b1;
      end
      always_ff @(posedge clk) begin
         if (ld_en && ld_idx == PW'(g)) pbuf[g] <= ld_byte;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         pg_q <= '0;
      end else if (commit && !busy) begin
         busy <= 1'b1;
         cnt  <= '0;
         pg_q <= pg;
      end else if (busy) begin
         if (cnt == CW'(WRITE_CYCLES - 1)) busy <= 1'b0;
         cnt <= cnt + 1'b1;
      end
   end

   assign wr_idx  = cnt[PW-1:0];
   assign in_win  = cnt < CW'(PAGE_BYTES);
   assign wr_addr = {pg_q, wr_idx};
   assign mem_we  = busy && in_win && pmask[wr_idx]
                    && !prot_hit(bp, wr_addr[ADDR_W-1 -: 2]);

   spi_nvm_array #(.ADDR_W(ADDR_W)) i_array (
      .clk  (clk),
      .we   (mem_we),
      .waddr(wr_addr),
      .wdata(pbuf[wr_idx]),
      .raddr(rd_addr),
      .rdata(rd_data)
   );

   a_r6_buf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |-> !busy);
   a_r9_bp_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $stable(bp));
endmodule

// File: rtl/spi_nvm_ctrl.sv
module spi_nvm_ctrl
   import spi_nvm_pkg::*;
#(
   parameter int ADDR_W       = 11,
   parameter int PAGE_BYTES   = 32,
   parameter int WRITE_CYCLES = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic mosi,
   input  logic hold_n,
   input  logic wp_n,
   output logic miso,
   output logic miso_oe
);
   localparam int PW  = $clog2(PAGE_BYTES);
   localparam int PGW = ADDR_W - PW;

   initial begin
      a_cfg_addr_fits: assert (ADDR_W <= 16 && ADDR_W > PW);
   end

   nvm_st_e           st;
   logic              idle, cs_end, byte_done, tx_load, busy;
   logic [7:0]        byte_val, tx_byte, rd_data, status, ahi;
   logic              wel, is_wr, got, sr_got, wp_q;
   logic [1:0]        bp, sr_val;
   logic [ADDR_W-1:0] addr, addr_full, addr_nxt, rd_addr;
   logic              ld_en, clr_mask, commit;

   spi_nvm_pins i_pins (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
      .hold_n(hold_n), .tx_load(tx_load), .tx_byte(tx_byte), .idle(idle),
      .cs_end(cs_end), .byte_done(byte_done), .byte_val(byte_val),
      .miso(miso), .miso_oe(miso_oe)
   );

   assign status    = {4'b0000, bp, wel, busy};
   assign addr_full = ADDR_W'({ahi, byte_val});
   assign addr_nxt  = addr + 1'b1;
   assign rd_addr   = (st == ST_ALO) ? addr_full : addr_nxt;
   assign ld_en     = byte_done && st == ST_WR;
   assign clr_mask  = byte_done && st == ST_ALO && is_wr;
   assign commit    = cs_end && st == ST_WR && got;

   always_comb begin
      tx_load = 1'b0;
      tx_byte = status;
      if (byte_done) begin
         case (st)
            ST_CMD:  tx_load = (byte_val == OP_RDSR);
            ST_ALO:  begin tx_load = !is_wr; tx_byte = rd_data; end
            ST_RD:   begin tx_load = 1'b1;   tx_byte = rd_data; end
            ST_RDSR: tx_load = 1'b1;
            default: tx_load = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wp_q <= 1'b1;
      else        wp_q <= wp_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_CMD;
         wel    <= 1'b0;
         bp     <= 2'd0;
         is_wr  <= 1'b0;
         got    <= 1'b0;
         sr_got <= 1'b0;
         sr_val <= 2'd0;
         ahi    <= '0;
         addr   <= '0;
      end else if (idle) begin
         st     <= ST_CMD;
         got    <= 1'b0;
         sr_got <= 1'b0;
         if (cs_end) begin
            if (st == ST_WR && got) wel <= 1'b0;
            if (st == ST_WRSR && sr_got) begin
               bp  <= sr_val;
               wel <= 1'b0;
            end
         end
      end else if (byte_done) begin
         case (st)
            ST_CMD: begin
               st <= ST_SKIP;
               if (!busy || byte_val == OP_RDSR) begin
                  case (byte_val)
                     OP_WREN:  wel <= 1'b1;
                     OP_WRDI:  wel <= 1'b0;
                     OP_RDSR:  st  <= ST_RDSR;
                     OP_WRSR:  if (wel && wp_q) st <= ST_WRSR;
                     OP_READ:  begin is_wr <= 1'b0; st <= ST_AHI; end
                     OP_WRITE: if (wel && wp_q) begin is_wr <= 1'b1; st <= ST_AHI; end
                     default:  st <= ST_SKIP;
                  endcase
               end
            end
            ST_AHI: begin ahi <= byte_val; st <= ST_ALO; end
            ST_ALO: begin
               addr <= addr_full;
               st   <= is_wr ? ST_WR : ST_RD;
            end
            ST_RD: addr <= addr_nxt;
            ST_WR: begin
               addr <= {addr[ADDR_W-1:PW], addr[PW-1:0] + 1'b1};
               got  <= 1'b1;
            end
            ST_WRSR: begin sr_val <= byte_val[3:2]; sr_got <= 1'b1; end
            default: st <= st;
         endcase
      end
   end

   spi_nvm_store #(
      .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
   ) i_store (
      .clk(clk), .rst_n(rst_n), .bp(bp), .ld_en(ld_en), .ld_idx(addr[PW-1:0]),
      .ld_byte(byte_val), .clr_mask(clr_mask), .commit(commit),
      .pg(addr[ADDR_W-1 -: PGW]), .rd_addr(rd_addr), .rd_data(rd_data),
      .busy(busy)
   );

   a_r7_wel_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !wel);
   a_r5_wr_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_AHI && $past(st) == ST_CMD && is_wr) |-> $past(wel && !busy && wp_q));
endmodule

// File: tb/test_spi_nvm_ctrl.sv
module test_spi_nvm_ctrl;
   localparam int AW = 8, PB = 32, WC = 600, HALF = 4, DEPTH = 256;

   logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, mosi = 0, hold_n = 1, wp_n = 1;
   wire  miso, miso_oe;
   int   n_cmp = 0, n_err = 0;
   bit   done = 0;
   logic [7:0] refm [DEPTH];
   logic [7:0] wbuf [64];
   logic [1:0] lvl = 2'd0;
   logic [7:0] s, d;

   always #4 clk = ~clk;

   spi_nvm_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) i_spi_nvm_ctrl (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
      .hold_n(hold_n), .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe)
   );

   task automatic tick(input int n); repeat (n) @(negedge clk); endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic sbit(input logic b, output logic r);
      mosi = b; tick(HALF); r = miso; sck = 1; tick(HALF); sck = 0;
   endtask

   task automatic xfer(input logic [7:0] o, output logic [7:0] i);
      for (int k = 7; k >= 0; k--) sbit(o[k], i[k]);
   endtask

   task automatic sel();   cs_n = 0; tick(HALF); endtask
   task automatic desel(); tick(HALF); cs_n = 1; tick(2 * HALF); endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] x; sel(); xfer(op, x); desel();
   endtask

   task automatic rdsr(output logic [7:0] st);
      logic [7:0] x; sel(); xfer(8'h05, x); xfer(8'h00, st); desel();
   endtask

   task automatic wrsr(input logic [7:0] v);
      logic [7:0] x; sel(); xfer(8'h01, x); xfer(v, x); desel();
   endtask

   task automatic wait_idle();
      logic [7:0] st;
      for (int k = 0; k < 50; k++) begin rdsr(st); if (!st[0]) break; end
   endtask

   function automatic bit prot(input int a, input logic [1:0] l);
      return (l == 3) || (l == 2 && a >= DEPTH / 2) || (l == 1 && a >= 3 * DEPTH / 4);
   endfunction

   task automatic do_write(input int a, input int n, input bit acc);
      logic [7:0] x;
      sel(); xfer(8'h02, x); xfer(8'(a >> 8), x); xfer(8'(a), x);
      for (int k = 0; k < n; k++) xfer(wbuf[k], x);
      desel();
      if (acc)
         for (int k = 0; k < n; k++) begin
            int ad;
            ad = ((a % DEPTH) & ~(PB - 1)) | ((a + k) & (PB - 1));
            if (!prot(ad, lvl)) refm[ad] = wbuf[k];
         end
   endtask

   task automatic chk_read(input int a, input int n, input string tag);
      logic [7:0] x;
      sel(); xfer(8'h03, x); xfer(8'(a >> 8), x); xfer(8'(a), x);
      for (int k = 0; k < n; k++) begin
         xfer(8'h00, x);
         chk(tag, x, refm[(a + k) % DEPTH]);
      end
      desel();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_err++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
         $finish;
      end
   end

   initial begin
      tick(5); rst_n = 1; tick(3);
      // R1 reset state
      chk("R1 oe", miso_oe, 0);
      rdsr(s); chk("R1 status", s, 8'h00);
      // R2 / R11 output enable
      cs_n = 0; tick(2); chk("R2 oe on", miso_oe, 1);
      hold_n = 0; tick(2); chk("R11 oe held", miso_oe, 0);
      hold_n = 1; tick(2); chk("R2 oe back", miso_oe, 1);
      cs_n = 1; tick(2); chk("R2 oe off", miso_oe, 0);
      // R3 latch set and clear
      cmd1(8'h06); rdsr(s); chk("R3 wel set", s, 8'h02);
      cmd1(8'h04); rdsr(s); chk("R3 wel clr", s, 8'h00);
      // fill the array, R7 on the first page
      for (int p = 0; p < DEPTH / PB; p++) begin
         for (int k = 0; k < PB; k++) wbuf[k] = 8'((p * PB + k) * 7 + 3);
         cmd1(8'h06);
         do_write(p * PB, PB, 1);
         if (p == 0) begin
            rdsr(s); chk("R7 busy wel clear", s, 8'h01);
            cmd1(8'h06); rdsr(s); chk("R7 opcode ignored busy", s, 8'h01);
         end
         wait_idle();
         if (p == 0) begin rdsr(s); chk("R7 busy done", s, 8'h00); end
      end
      // R4 sequential read with wrap and ignored upper address bits
      chk_read(16'hFFF0, DEPTH + 16, "R4");
      // R5 write without latch
      for (int k = 0; k < 4; k++) wbuf[k] = 8'hF0 + 8'(k);
      do_write(8'h10, 4, 0);
      rdsr(s); chk("R5 no busy", s, 8'h00);
      chk_read(8'h10, 4, "R5");
      // R6 page wrap and dropped partial byte
      for (int k = 0; k < 4; k++) wbuf[k] = 8'hA0 + 8'(k);
      cmd1(8'h06);
      sel(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h3E, d);
      for (int k = 0; k < 4; k++) xfer(wbuf[k], d);
      for (int k = 0; k < 3; k++) sbit(1'b1, d[0]);
      desel();
      refm[8'h3E] = 8'hA0; refm[8'h3F] = 8'hA1; refm[8'h20] = 8'hA2; refm[8'h21] = 8'hA3;
      wait_idle();
      chk_read(8'h20, PB, "R6");
      // R10 write-protect pin
      wp_n = 0; cmd1(8'h06);
      wbuf[0] = 8'hEE; do_write(8'h50, 1, 0);
      rdsr(s); chk("R10 write ignored", s, 8'h02);
      wrsr(8'h0C); rdsr(s); chk("R10 wrsr ignored", s, 8'h02);
      wp_n = 1; chk_read(8'h50, 1, "R10");
      cmd1(8'h04);
      // R8 status write needs latch
      wrsr(8'h0C); rdsr(s); chk("R8 no latch", s, 8'h00);
      for (int l = 1; l < 4; l++) begin
         cmd1(8'h06); wrsr(8'(l << 2));
         rdsr(s); chk("R8 level", s, 32'(l << 2));
         lvl = 2'(l);
         for (int q = 0; q < 4; q++) begin
            cmd1(8'h06);
            wbuf[0] = 8'(8'h40 + l * 16 + q);
            do_write(q * 64 + 5 + l, 1, 1);
            wait_idle();
         end
         for (int q = 0; q < 4; q++) chk_read(q * 64 + 5 + l, 1, "R9");
      end
      cmd1(8'h06); wrsr(8'h00); lvl = 2'd0;
      rdsr(s); chk("R8 restore", s, 8'h00);
      // R11 hold in the middle of a data byte
      cmd1(8'h06);
      sel(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h80, d);
      for (int k = 7; k >= 4; k--) sbit(8'hC3 >> k, d[0]);
      hold_n = 0; tick(2);
      chk("R11 oe in hold", miso_oe, 0);
      for (int k = 0; k < 3; k++) begin
         mosi = ~mosi; sck = 1; tick(HALF); sck = 0; tick(HALF);
      end
      hold_n = 1; tick(HALF);
      for (int k = 3; k >= 0; k--) sbit(8'hC3 >> k, d[0]);
      desel();
      refm[8'h80] = 8'hC3;
      wait_idle();
      chk_read(8'h80, 1, "R11");
      // R11 select ends a held transfer
      sel(); xfer(8'h05, d);
      for (int k = 0; k < 4; k++) sbit(1'b0, d[0]);
      hold_n = 0; tick(2); cs_n = 1; tick(4); hold_n = 1; tick(4);
      rdsr(s); chk("R11 cs in hold", s, 8'h00);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   end
endmodule